// File: doc/BRIEF.md
# Programmable Bus Waveform Sequencer

This block is a bus-master engine that moves data between an internal FIFO and an external parallel device. Bus timing is not fixed. A small table of up to eight waveform vectors is loaded through a register port. The engine then plays that table one vector at a time. Each vector does four things:

- It sets six control lines.
- It can hold until a chosen pattern appears on six ready inputs.
- It can move one FIFO word across the data bus.
- It can step a nine-bit address counter.

One pass through the table, ending on a vector marked last, counts as one transaction. A 32-bit transaction counter counts down after each pass. When it reaches zero the engine stops and raises a done flag. Until then it restarts the table at vector 0, so long transfers need no attention from software.

The data direction, the bus width (8 or 16 bits) and a two-bit FIFO select come from a configuration register. Whenever a vector moves a word and the FIFO cannot take it, or has nothing to give, the engine holds on that vector. This prevents both overflow and underflow.

Top module: `wave_seq`

## Requirements
- R1: While `rst` is high and after it is released, `ctl_out`, `addr_out`, `dbus_out`, `tc_remaining` and `fifo_sel` are 0, and `busy` and `done` are low.
- R2: Register writes use the following map:
  - offsets 0 to 7 hold vectors 0 to 7;
  - offset 8 holds the transaction count;
  - offset 9 holds the configuration: bit 0 is direction (1 = FIFO to device), bit 1 is width (1 = 16 bits), bits 3:2 are the FIFO select;
  - offset 10 holds the start address;
  - a write to offset 11 starts a run.

  Every write made while `busy` is high is ignored. A start with a count of 0 is ignored.
- R3: A vector word is laid out as follows: control levels in bits 5:0, ready mask in bits 11:6, ready polarity in bits 17:12, next index in bits 20:18, FIFO-advance in bit 21, address-increment in bit 22, last flag in bit 23. From the cycle after the start edge, `ctl_out` shows the control field of the active vector. A vector with a zero mask lasts exactly one cycle, so the control lines can change on every clock.
- R4: A vector stays active while any masked ready input differs from its polarity bit.
- R5: When a vector finishes, the next vector depends on the last flag:
  - last flag clear: the vector named in its next field becomes active;
  - last flag set: the transaction counter drops by one and vector 0 follows.
- R6: A FIFO-advance vector holds without popping or pushing in two cases: the direction is FIFO to device and `fifo_empty` is high, or the direction is device to FIFO and `fifo_full` is high.
- R7: In the device-to-FIFO direction, a finishing FIFO-advance vector pulses `fifo_push` in that same cycle, with `fifo_wdata` equal to `dbus_in`. In 8-bit mode the upper byte of `fifo_wdata` is 0.
- R8: In the FIFO-to-device direction, a finishing FIFO-advance vector pulses `fifo_pop`, and `dbus_out` holds the popped word from the next cycle on. `dbus_oe` is high exactly while a FIFO-to-device run is active.
- R9: A finishing address-increment vector adds 1 to `addr_out`, wrapping modulo 512.
- R10: When the last vector finishes with a count of 1, `busy` falls, `ctl_out` returns to 0 and `done` rises. `done` stays high until the next accepted start.
- R11: `fifo_sel` shows the select field of the configuration register.
- R12: `tc_remaining` always shows the number of transactions still to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | interface clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 4 | register offset |
| reg_wdata | input | 32 | register write data |
| rdy_in | input | 6 | ready inputs from the device |
| dbus_in | input | DATA_W | data bus from the device |
| fifo_empty | input | 1 | FIFO has no word to send |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_rdata | input | DATA_W | head word of the FIFO |
| ctl_out | output | 6 | control lines |
| addr_out | output | ADDR_W | address bus |
| dbus_out | output | DATA_W | data bus to the device |
| dbus_oe | output | 1 | drive enable for dbus_out |
| fifo_sel | output | 2 | FIFO select |
| fifo_pop | output | 1 | take the head word from the FIFO |
| fifo_push | output | 1 | write fifo_wdata into the FIFO |
| fifo_wdata | output | DATA_W | word written into the FIFO |
| busy | output | 1 | run in progress |
| done | output | 1 | last run reached a count of zero |
| tc_remaining | output | CNT_W | transactions left |

## Verification
The assertions check several properties on every cycle:
- no pop from an empty FIFO and no push into a full one;
- never a pop and a push together;
- the transaction count and the address only ever step by one during a run;
- `done` rises only with the count at zero and the engine idle;
- the control lines and the drive enable stay quiet while idle.

Other behaviours only the bench scenarios can show:
- the vector ordering through next-index branches;
- waiting on ready patterns;
- the restart at vector 0;
- the exact words crossing the bus in each width;
- the writes and starts that must be ignored.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int CTL_W  = 6;
  localparam int RDY_W  = 6;
  localparam int IDX_W  = 3;
  localparam int NVEC   = 1 << IDX_W;
  localparam int RA_W   = 4;

  typedef struct packed {
    logic             last;
    logic             addr_inc;
    logic             fifo_adv;
    logic [IDX_W-1:0] next;
    logic [RDY_W-1:0] pol;
    logic [RDY_W-1:0] mask;
    logic [CTL_W-1:0] ctl;
  } vec_t;

  localparam int VEC_W = $bits(vec_t);

  localparam logic [RA_W-1:0] RA_COUNT = 4'd8;
  localparam logic [RA_W-1:0] RA_CFG   = 4'd9;
  localparam logic [RA_W-1:0] RA_ADDR  = 4'd10;
  localparam logic [RA_W-1:0] RA_START = 4'd11;
endpackage

// File: rtl/wseq_vecmem.sv
module wseq_vecmem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wseq_cond.sv
module wseq_cond
  import wseq_pkg::*;
(
  input  vec_t             vec,
  input  logic [RDY_W-1:0] rdy_in,
  input  logic             dir_out,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  output logic             ready_ok,
  output logic             stall
);
  always_comb begin
    ready_ok = ((rdy_in ^ vec.pol) & vec.mask) == '0;
    stall    = vec.fifo_adv && (dir_out ? fifo_empty : fifo_full);
  end
endmodule

// File: rtl/wseq_txcount.sv
module wseq_txcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             at_one,
  output logic             at_zero
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - CNT_W'(1);
  end

  assign at_one  = count == CNT_W'(1);
  assign at_zero = count == '0;
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [RDY_W-1:0]  rdy_in,
  input  logic [DATA_W-1:0] dbus_in,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic [CTL_W-1:0]  ctl_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  output logic [1:0]        fifo_sel,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  tc_remaining
);
  localparam int HALF = DATA_W / 2;

  logic             busy_q, done_q, dir_q, wide_q;
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q, data_mask;
  logic [VEC_W-1:0] cur_raw;
  vec_t             cur;
  logic             idle_wr, start_req, ready_ok, stall, step, xfer, fin, busy_n;
  logic             tc_one, tc_zero, tc_load;

  assign idle_wr   = reg_we && !busy_q;
  assign tc_load   = idle_wr && reg_addr == RA_COUNT;
  assign start_req = idle_wr && reg_addr == RA_START && !tc_zero;

  wseq_vecmem #(.DEPTH(NVEC), .WIDTH(VEC_W)) u_mem (
    .clk   (clk),
    .we    (idle_wr && !reg_addr[RA_W-1]),
    .waddr (reg_addr[IDX_W-1:0]),
    .wdata (reg_wdata[VEC_W-1:0]),
    .raddr (idx_n),
    .rdata (cur_raw)
  );
  assign cur = vec_t'(cur_raw);

  wseq_cond u_cond (
    .vec        (cur),
    .rdy_in     (rdy_in),
    .dir_out    (dir_q),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .ready_ok   (ready_ok),
    .stall      (stall)
  );

  wseq_txcount #(.CNT_W(CNT_W)) u_tc (
    .clk      (clk),
    .rst      (rst),
    .load     (tc_load),
    .load_val (reg_wdata[CNT_W-1:0]),
    .dec      (step && cur.last),
    .count    (tc_remaining),
    .at_one   (tc_one),
    .at_zero  (tc_zero)
  );

  assign step = busy_q && ready_ok && !stall;
  assign xfer = step && cur.fifo_adv;
  assign fin  = step && cur.last && tc_one;

  always_comb begin
    busy_n = busy_q;
    if (start_req) busy_n = 1'b1;
    else if (fin)  busy_n = 1'b0;
    idx_n = idx_q;
    if (start_req) idx_n = '0;
    else if (step) idx_n = cur.last ? '0 : cur.next;
  end

  generate
    if (DATA_W > 8) begin : g_split
      assign data_mask = wide_q ? '1 : {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};
    end else begin : g_byte
      assign data_mask = '1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      sel_q  <= '0;
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      if (start_req) done_q <= 1'b0;
      else if (fin)  done_q <= 1'b1;
      if (idle_wr && reg_addr == RA_CFG) begin
        dir_q  <= reg_wdata[0];
        wide_q <= reg_wdata[1];
        sel_q  <= reg_wdata[3:2];
      end
      if (idle_wr && reg_addr == RA_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
      else if (step && cur.addr_inc)      addr_q <= addr_q + ADDR_W'(1);
      if (xfer && dir_q) dout_q <= fifo_rdata & data_mask;
    end
  end

  assign ctl_out    = busy_q ? cur.ctl : '0;
  assign addr_out   = addr_q;
  assign dbus_out   = dout_q;
  assign dbus_oe    = busy_q && dir_q;
  assign fifo_sel   = sel_q;
  assign fifo_pop   = xfer && dir_q;
  assign fifo_push  = xfer && !dir_q;
  assign fifo_wdata = dbus_in & data_mask;
  assign busy       = busy_q;
  assign done       = done_q;
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 32,
  parameter int CTL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              fifo_pop,
  input logic              fifo_push,
  input logic              busy,
  input logic              done,
  input logic              dbus_oe,
  input logic [CTL_W-1:0]  ctl_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  tc_remaining
);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> !fifo_full);
  a_r8_one_dir: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_push);
  a_r8_oe_busy: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> busy);
  a_r3_idle_ctl: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ctl_out == '0);
  a_r10_done_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && tc_remaining == '0));
  a_r12_tc_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && tc_remaining != $past(tc_remaining))
      |-> tc_remaining == $past(tc_remaining) - CNT_W'(1));
  a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && addr_out != $past(addr_out))
      |-> addr_out == $past(addr_out) + ADDR_W'(1));
endmodule

bind wave_seq wave_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(wseq_pkg::CTL_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .fifo_pop(fifo_pop), .fifo_push(fifo_push), .busy(busy), .done(done),
  .dbus_oe(dbus_oe), .ctl_out(ctl_out), .addr_out(addr_out),
  .tc_remaining(tc_remaining)
);

// File: tb/test_wave_seq.sv
module test_wave_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [5:0]  rdy_in = '0;
  logic [15:0] dbus_in = '0;
  logic        fifo_full = 1'b0;
  logic        hold_empty = 1'b1;
  logic        fifo_empty;
  logic [15:0] fifo_rdata;
  logic [5:0]  ctl_out;
  logic [8:0]  addr_out;
  logic [15:0] dbus_out, fifo_wdata;
  logic        dbus_oe, fifo_pop, fifo_push, busy, done;
  logic [1:0]  fifo_sel;
  logic [31:0] tc_remaining;

  int total = 0;
  int bad = 0;
  logic [15:0] src [2];
  int sidx = 0;
  logic [15:0] exp_in_q [$];
  logic [15:0] exp_out_q [$];
  logic pend_pop = 1'b0;

  always #2.5 clk = ~clk;

  assign fifo_rdata = src[sidx % 2];
  assign fifo_empty = hold_empty || sidx >= 2;
  always @(posedge clk) if (fifo_pop) sidx <= sidx + 1;

  wave_seq i_wave_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rdy_in(rdy_in), .dbus_in(dbus_in), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_rdata(fifo_rdata), .ctl_out(ctl_out), .addr_out(addr_out), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe), .fifo_sel(fifo_sel), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .busy(busy), .done(done), .tc_remaining(tc_remaining)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] vec(input logic [5:0] ctl, input logic [5:0] mask,
      input logic [5:0] pol, input logic [2:0] nxt, input bit adv, input bit inc, input bit last);
    return {8'h00, last, inc, adv, nxt, pol, mask, ctl};
  endfunction

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check(done, tag, done, 1);
  endtask

  // Monitor: scoreboard compare as the design produces words.
  always @(negedge clk) begin
    if (!rst) begin
      if (pend_pop) begin
        if (exp_out_q.size() == 0) check(1'b0, "R8 unexpected pop", dbus_out, 0);
        else begin
          logic [15:0] e;
          e = exp_out_q.pop_front();
          check(dbus_out == e, "R8 dbus_out word", dbus_out, e);
        end
      end
      pend_pop <= fifo_pop;
      if (fifo_push) begin
        if (exp_in_q.size() == 0) check(1'b0, "R7 unexpected push", fifo_wdata, 0);
        else begin
          logic [15:0] e;
          e = exp_in_q.pop_front();
          check(fifo_wdata == e, "R7 fifo_wdata", fifo_wdata, e);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ctl_out == 0 && busy == 0 && done == 0, "R1 ctl/busy/done", {ctl_out, busy, done}, 0);
    check(addr_out == 0 && tc_remaining == 0, "R1 addr/count", {addr_out, tc_remaining}, 0);
    check(dbus_out == 0 && fifo_sel == 0, "R1 dbus/sel", {dbus_out, fifo_sel}, 0);

    // Table: 0 -> 3 -> 1 (wait rdy0, move word, step addr) -> 2 (last)
    wr(4'd0, vec(6'h01, 6'h00, 6'h00, 3'd3, 0, 0, 0));
    wr(4'd3, vec(6'h08, 6'h00, 6'h00, 3'd1, 0, 0, 0));
    wr(4'd1, vec(6'h02, 6'h01, 6'h01, 3'd2, 1, 1, 0));
    wr(4'd2, vec(6'h04, 6'h00, 6'h00, 3'd0, 0, 0, 1));

    // Scenario A: device to FIFO, 8-bit, select 1
    wr(4'd9, 32'h4);
    wr(4'd10, 32'h1FE);
    wr(4'd8, 32'd3);
    dbus_in = 16'hA5C3;
    rdy_in = 6'h00;
    repeat (3) exp_in_q.push_back(16'h00C3);
    wr(4'd11, 0);
    @(negedge clk);
    check(busy == 1 && ctl_out == 6'h01, "R3 first vector", ctl_out, 1);
    check(fifo_sel == 2'd1, "R11 fifo_sel", fifo_sel, 1);
    check(tc_remaining == 3, "R12 count loaded", tc_remaining, 3);
    @(negedge clk);
    check(ctl_out == 6'h08, "R5 branch to vector 3", ctl_out, 8);
    @(negedge clk);
    check(ctl_out == 6'h02, "R5 branch to vector 1", ctl_out, 2);
    repeat (3) begin
      @(negedge clk);
      check(ctl_out == 6'h02 && !fifo_push, "R4 wait on ready", {ctl_out, fifo_push}, 4);
    end
    @(posedge clk); #1;
    rdy_in = 6'h3F; fifo_full = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(ctl_out == 6'h02 && !fifo_push, "R6 hold on full", {ctl_out, fifo_push}, 4);
    end
    @(posedge clk); #1;
    fifo_full = 1'b0;
    @(negedge clk);
    check(fifo_push == 1'b1, "R7 push pulse", fifo_push, 1);
    @(negedge clk);
    check(ctl_out == 6'h04 && tc_remaining == 3, "R5 last vector", {ctl_out, tc_remaining}, 'h43);
    @(negedge clk);
    check(ctl_out == 6'h01, "R5 restart at vector 0", ctl_out, 1);
    check(tc_remaining == 2, "R12 count after pass", tc_remaining, 2);
    wait_done("R10 done after scenario A");
    check(!busy && ctl_out == 0 && tc_remaining == 0, "R10 idle after done",
          {busy, ctl_out, tc_remaining}, 0);
    check(addr_out == 9'h001, "R9 address wraps", addr_out, 1);
    check(exp_in_q.size() == 0, "R7 all words pushed", exp_in_q.size(), 0);

    // R2: start with zero count ignored
    wr(4'd11, 0);
    @(negedge clk);
    check(!busy && done, "R2 zero-count start ignored", {busy, done}, 1);

    // Scenario B: FIFO to device, 16-bit, select 2
    wr(4'd9, 32'hB);
    wr(4'd10, 32'h010);
    wr(4'd8, 32'd2);
    src[0] = 16'h1234; src[1] = 16'hBEEF;
    sidx = 0;
    hold_empty = 1'b1;
    exp_out_q.push_back(16'h1234);
    exp_out_q.push_back(16'hBEEF);
    wr(4'd11, 0);
    @(negedge clk);
    check(busy && !done, "R10 done cleared on start", {busy, done}, 2);
    check(dbus_oe == 1'b1, "R8 drive enable", dbus_oe, 1);
    check(fifo_sel == 2'd2, "R11 fifo_sel update", fifo_sel, 2);
    repeat (4) @(negedge clk);
    check(ctl_out == 6'h02 && !fifo_pop, "R6 hold on empty", {ctl_out, fifo_pop}, 4);
    wr(4'd8, 32'd100);
    @(negedge clk);
    check(tc_remaining == 2, "R2 write while busy ignored", tc_remaining, 2);
    @(posedge clk); #1;
    hold_empty = 1'b0;
    wait_done("R10 done after scenario B");
    @(negedge clk);
    check(addr_out == 9'h012, "R9 address steps", addr_out, 'h12);
    check(exp_out_q.size() == 0, "R8 all words sent", exp_out_q.size(), 0);
    check(!dbus_oe, "R8 drive enable off", dbus_oe, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule